// File: doc/BRIEF.md
# I/O Access Dword Splitter

This block sits between a processor-side port-access request stream and a dword-wide downstream transaction stream. Each request names a 16-bit port address, a length of 1, 2 or 4 bytes, a direction and (for writes) data. The block turns the request into one dword-aligned transaction when all bytes share a dword, or into two when the bytes straddle a 4-byte boundary. The lower dword always goes first. Every transaction carries a byte-enable mask and a 17-bit address. The extra top bit lets an access that runs past port FFFFh reach three more bytes at 10000h..10002h instead of wrapping to port 0.

Write data is steered into the byte lanes of each dword. For reads, the block accepts one data word per issued transaction, in issue order, on a separate return stream. It shifts and merges the words into a single response whose byte k is the byte read from address (port + k). All three streams use valid/ready. A request must hold its valid and its fields until ready is seen. The block raises request ready only in the cycle its last transaction is accepted. While downstream ready is low, the offered transaction holds steady. A read response stays valid and unchanged until the consumer takes it. No new request is issued while a read is waiting for data or for its response to be taken.

Top module: `io_split_top`

## Requirements
- R1: After reset, and with no request offered, dn_valid, req_ready and rsp_valid are all 0.
- R2: When all bytes of a request fall in one dword, exactly one transaction is issued. Its dn_addr is the request address with bits [1:0] cleared and bit 16 zero. dn_be holds `req_bytes` consecutive ones starting at lane `req_addr[1:0]`. For a write, request byte k (req_wdata[8k+7:8k]) appears in dn_wdata lane (req_addr[1:0]+k).
- R3: A request whose bytes straddle a 4-byte boundary is issued as two transactions, the lower dword first. The second address is the first plus 4. The masks cover only the request's bytes in each dword and together hold `req_bytes` ones. Write bytes are steered into their lanes in both halves.
- R4: Bytes beyond port FFFFh go in a second transaction at dn_addr 10000h, with bit 16 set and lanes 0..2 enabled as needed. This applies to a 4-byte access at FFFDh, FFFEh or FFFFh and to a 2-byte access at FFFFh. Lane 3 is never enabled at that address.
- R5: req_ready is 1 only in the cycle where the request's last transaction is accepted (dn_valid and dn_ready both 1). It is never 1 on the first half of a split.
- R6: While dn_valid is 1 and dn_ready is 0, dn_valid stays 1 and dn_addr, dn_be, dn_write and the enabled dn_wdata lanes stay unchanged.
- R7: A read produces one response. rsp_data byte k, for k below the length, is the byte at address (port + k) taken from the returned lanes. All higher bytes are 0. rsp_valid and rsp_data hold until rsp_ready.
- R8: rd_ready is 1 exactly while some issued read transaction has not yet returned data. No transaction is offered from the last issue of a read until its response is taken.
- R9: A write produces no response (rsp_valid stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request done; high when its last transaction is accepted |
| req_addr | input | 16 | Port address of first byte |
| req_bytes | input | 3 | Length in bytes: 1, 2 or 4 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write bytes; byte k at bits [8k+7:8k] |
| dn_valid | output | 1 | Transaction offered |
| dn_ready | input | 1 | Transaction accepted |
| dn_addr | output | 17 | Dword-aligned address, bit 16 = wrap region |
| dn_be | output | 4 | Byte-lane enables |
| dn_write | output | 1 | Transaction direction |
| dn_wdata | output | 32 | Write data placed in byte lanes |
| rd_valid | input | 1 | Read data word returned |
| rd_ready | output | 1 | Read data can be taken |
| rd_data | input | 32 | Returned dword, by lane |
| rsp_valid | output | 1 | Merged read response available |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 32 | Merged read bytes; byte k at bits [8k+7:8k] |

## Verification
Two functions can fall in the same cycle. The data return for the first half of a split read can be accepted while the second half is still being offered or accepted downstream. The bench provokes this with a responder that may return data in the cycle right after issue, while it randomly stalls dn_ready. The return is judged correct when rd_ready follows the bench's own count of outstanding reads every clock, and the merged response matches the bytes the bench memory holds at port + k, including across the wrap to 10000h.

// File: rtl/io_split_pkg.sv
package io_split_pkg;
  typedef enum logic [1:0] {
    ST_FIRST  = 2'd0,
    ST_SECOND = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RSP    = 2'd3
  } split_state_e;
endpackage

// File: rtl/io_split_decode.sv
module io_split_decode #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int WA_W  = ADDR_W + 1,
  localparam int DW_W  = WA_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  nbytes,
  output logic [DW_W-1:0]   lo_dw,
  output logic [DW_W-1:0]   hi_dw,
  output logic [LANES-1:0]  lo_be,
  output logic [LANES-1:0]  hi_be,
  output logic              crosses,
  output logic [OFF_W-1:0]  first_off
);
  logic [WA_W-1:0]  first_b;
  logic [WA_W-1:0]  last_b;
  logic [OFF_W-1:0] last_off;

  // widen by one bit so the top of the space spills into the wrap region
  assign first_b   = {1'b0, addr};
  assign last_b    = first_b + WA_W'(nbytes) - WA_W'(1);
  assign lo_dw     = first_b[WA_W-1:OFF_W];
  assign hi_dw     = last_b[WA_W-1:OFF_W];
  assign crosses   = (lo_dw != hi_dw);
  assign first_off = first_b[OFF_W-1:0];
  assign last_off  = last_b[OFF_W-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LI = OFF_W'(i);
    assign lo_be[i] = (LI >= first_off) && (crosses || (LI <= last_off));
    assign hi_be[i] = crosses && (LI <= last_off);
  end
endmodule

// File: rtl/io_split_lanes.sv
module io_split_lanes #(
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int W     = 8 * LANES
) (
  input  logic [W-1:0]     wdata,
  input  logic [OFF_W-1:0] off,
  output logic [W-1:0]     lo_data,
  output logic [W-1:0]     hi_data
);
  logic [2*W-1:0] wide;

  assign wide    = {{W{1'b0}}, wdata} << (8 * off);
  assign lo_data = wide[W-1:0];
  assign hi_data = wide[2*W-1:W];
endmodule

// File: rtl/io_split_merge.sv
module io_split_merge #(
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int W     = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             cap_hi,
  input  logic [W-1:0]     cap_data,
  input  logic [OFF_W-1:0] off,
  input  logic [CNT_W-1:0] nbytes,
  output logic [W-1:0]     merged
);
  logic [W-1:0]   lo_word;
  logic [W-1:0]   hi_word;
  logic [2*W-1:0] joined;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_word <= '0;
      hi_word <= '0;
    end else if (cap_en) begin
      if (cap_hi) hi_word <= cap_data;
      else        lo_word <= cap_data;
    end
  end

  assign joined = {hi_word, lo_word} >> (8 * off);

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign merged[8*i +: 8] = (CNT_W'(i) < nbytes) ? joined[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/io_split_top.sv
module io_split_top
  import io_split_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int DW_W  = ADDR_W + 1 - OFF_W,
  localparam int W     = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic              req_write,
  input  logic [W-1:0]      req_wdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W:0]   dn_addr,
  output logic [LANES-1:0]  dn_be,
  output logic              dn_write,
  output logic [W-1:0]      dn_wdata,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [W-1:0]      rd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [W-1:0]      rsp_data
);
  split_state_e     state_q, state_d;
  logic [1:0]       issued_q, got_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] nbytes_q;
  logic [ADDR_W:0]  first_addr_q;

  logic [DW_W-1:0]  lo_dw, hi_dw;
  logic [LANES-1:0] lo_be, hi_be;
  logic             crosses;
  logic [OFF_W-1:0] first_off;
  logic [W-1:0]     lo_data, hi_data;

  logic in_issue, on_hi, dn_fire, rd_fire, last_half, rd_done;

  io_split_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_decode (
    .addr(req_addr), .nbytes(req_bytes), .lo_dw(lo_dw), .hi_dw(hi_dw),
    .lo_be(lo_be), .hi_be(hi_be), .crosses(crosses), .first_off(first_off)
  );

  io_split_lanes #(.LANES(LANES)) u_lanes (
    .wdata(req_wdata), .off(first_off), .lo_data(lo_data), .hi_data(hi_data)
  );

  io_split_merge #(.LANES(LANES)) u_merge (
    .clk(clk), .rst_n(rst_n), .cap_en(rd_fire), .cap_hi(got_q[0]),
    .cap_data(rd_data), .off(off_q), .nbytes(nbytes_q), .merged(rsp_data)
  );

  assign in_issue  = (state_q == ST_FIRST) || (state_q == ST_SECOND);
  assign on_hi     = (state_q == ST_SECOND);
  assign dn_valid  = req_valid && in_issue;
  assign dn_addr   = {(on_hi ? hi_dw : lo_dw), {OFF_W{1'b0}}};
  assign dn_be     = on_hi ? hi_be : lo_be;
  assign dn_wdata  = on_hi ? hi_data : lo_data;
  assign dn_write  = req_write;
  assign dn_fire   = dn_valid && dn_ready;
  assign last_half = on_hi || !crosses;
  assign req_ready = dn_fire && last_half;

  assign rd_ready  = (got_q != issued_q);
  assign rd_fire   = rd_valid && rd_ready;
  assign rd_done   = rd_fire && ((got_q + 2'd1) == issued_q);
  assign rsp_valid = (state_q == ST_RSP);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FIRST: if (dn_fire) begin
        if (crosses)         state_d = ST_SECOND;
        else if (!req_write) state_d = ST_WAIT;
      end
      ST_SECOND: if (dn_fire) state_d = req_write ? ST_FIRST : ST_WAIT;
      ST_WAIT:   if (rd_done) state_d = ST_RSP;
      ST_RSP:    if (rsp_ready) state_d = ST_FIRST;
      default:   state_d = ST_FIRST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_FIRST;
      issued_q     <= 2'd0;
      got_q        <= 2'd0;
      off_q        <= '0;
      nbytes_q     <= '0;
      first_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RSP && rsp_ready) begin
        issued_q <= 2'd0;
        got_q    <= 2'd0;
      end else begin
        if (dn_fire && !req_write) issued_q <= issued_q + 2'd1;
        if (rd_fire)               got_q    <= got_q + 2'd1;
      end
      if (dn_fire && !req_write) begin
        off_q    <= first_off;
        nbytes_q <= req_bytes;
      end
      if (dn_fire && !on_hi) first_addr_q <= dn_addr;
    end
  end

  // R2
  single_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !crosses) |-> ($countones(dn_be) == int'(req_bytes)));

  // R3
  split_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_issue && crosses) |->
      (($countones(lo_be) + $countones(hi_be)) == int'(req_bytes)));

  // R3
  split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_hi && dn_valid) |-> (dn_addr == first_addr_q + (ADDR_W+1)'(LANES)));

  // R4
  wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_addr[ADDR_W]) |->
      ((dn_addr[ADDR_W-1:0] == '0) && !dn_be[LANES-1]));

  // R6
  hold_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=>
      (dn_valid && $stable(dn_addr) && $stable(dn_be) && $stable(dn_write)));

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !dn_valid);
endmodule

// File: tb/io_split_top_tb.sv
`timescale 1ns/1ps
module io_split_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_bytes = 3'd1;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic [16:0] dn_addr;
  logic [3:0]  dn_be;
  logic        dn_write;
  logic [31:0] dn_wdata;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [31:0] rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;

  always #4 clk = ~clk;

  io_split_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_write(req_write),
    .req_wdata(req_wdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_addr(dn_addr), .dn_be(dn_be), .dn_write(dn_write), .dn_wdata(dn_wdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  typedef struct {
    logic [16:0] addr;
    logic [3:0]  be;
    logic        wr;
    logic [31:0] wdata;
    logic        last;
    logic        split;
  } tx_t;

  tx_t         exp_tx[$];
  logic [31:0] exp_rsp[$];
  logic [31:0] rd_q[$];
  int checks = 0;
  int errors = 0;
  int outstanding = 0;
  bit read_busy = 0;
  bit stall_heavy = 0;

  function automatic logic [7:0] mem_byte(input logic [16:0] a);
    logic [16:0] t;
    t = (a * 17'd29) ^ (a >> 5);
    return t[7:0] ^ {7'b0, a[16]};
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // behavioural model: walk the bytes, open a new transaction per dword
  task automatic plan_req(input logic [15:0] addr, input int n, input bit wr,
                          input logic [31:0] wd);
    tx_t t;
    logic [16:0] a0, a;
    logic [31:0] r;
    tx_t first;
    bit two;
    a0 = {1'b0, addr};
    two = ((a0 + 17'(n - 1)) >> 2) != (a0 >> 2);
    t.addr = {a0[16:2], 2'b00}; t.be = '0; t.wdata = '0; t.wr = wr;
    t.last = 1'b0; t.split = two;
    for (int k = 0; k < n; k++) begin
      a = a0 + 17'(k);
      if (a[16:2] != t.addr[16:2]) begin
        first = t;
        exp_tx.push_back(first);
        t.addr = {a[16:2], 2'b00}; t.be = '0; t.wdata = '0;
      end
      t.be[a[1:0]] = 1'b1;
      t.wdata[8*a[1:0] +: 8] = wd[8*k +: 8];
    end
    t.last = 1'b1;
    exp_tx.push_back(t);
    if (!wr) begin
      r = '0;
      for (int k = 0; k < n; k++) r[8*k +: 8] = mem_byte(a0 + 17'(k));
      exp_rsp.push_back(r);
    end
  endtask

  task automatic do_req(input logic [15:0] addr, input int n, input bit wr,
                        input logic [31:0] wd);
    @(posedge clk); #1;
    plan_req(addr, n, wr, wd);
    req_addr = addr; req_bytes = 3'(n); req_write = wr; req_wdata = wd;
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // random back-pressure and read returns, driven after each edge
  always @(posedge clk) begin
    #1;
    dn_ready  = stall_heavy ? ($urandom % 4 == 0) : ($urandom % 5 != 0);
    rsp_ready = ($urandom % 3 != 0);
    if (rd_q.size() > 0 && ($urandom % 4 != 0)) begin
      rd_valid = 1'b1;
      rd_data  = rd_q[0];
    end else begin
      rd_valid = 1'b0;
      rd_data  = $urandom;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit fire;
      tx_t f;
      string tag;
      logic [31:0] m, d;
      fire = dn_valid && dn_ready;
      if (dn_valid && read_busy)
        check(1'b0, "R8", "transaction offered while read pending", 32'(dn_addr), 32'h0);
      if (dn_valid) begin
        if (exp_tx.size() == 0) begin
          check(1'b0, "R2", "unexpected transaction", 32'(dn_addr), 32'h0);
        end else begin
          f = exp_tx[0];
          tag = !fire ? "R6" : (f.addr[16] ? "R4" : (f.split ? "R3" : "R2"));
          check(dn_addr == f.addr, tag, "dn_addr", 32'(dn_addr), 32'(f.addr));
          check(dn_be == f.be, tag, "dn_be", 32'(dn_be), 32'(f.be));
          check(dn_write == f.wr, tag, "dn_write", 32'(dn_write), 32'(f.wr));
          if (f.wr) begin
            m = lane_mask(f.be);
            check((dn_wdata & m) == f.wdata, tag, "dn_wdata lanes", dn_wdata & m, f.wdata);
          end
        end
      end
      check(req_ready == (fire && exp_tx.size() > 0 && exp_tx[0].last),
            "R5", "req_ready", 32'(req_ready), 32'(fire));
      check(rd_ready == (outstanding > 0), "R8", "rd_ready", 32'(rd_ready),
            32'(outstanding > 0));
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) begin
          check(1'b0, "R9", "response with none expected", rsp_data, 32'h0);
        end else if (rsp_ready) begin
          check(rsp_data == exp_rsp[0], "R7", "rsp_data", rsp_data, exp_rsp[0]);
          void'(exp_rsp.pop_front());
          read_busy = 0;
        end
      end
      if (fire && exp_tx.size() > 0) begin
        f = exp_tx.pop_front();
        if (!dn_write) begin
          for (int i = 0; i < 4; i++)
            d[8*i +: 8] = dn_be[i] ? mem_byte(dn_addr + 17'(i)) : 8'($urandom);
          rd_q.push_back(d);
          outstanding++;
          if (f.last) read_busy = 1;
        end
      end
      if (rd_valid && rd_ready) begin
        void'(rd_q.pop_front());
        outstanding--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: got no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a;
    int n;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!dn_valid, "R1", "dn_valid in reset", 32'(dn_valid), 32'h0);
    check(!rsp_valid, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!dn_valid && !req_ready, "R1", "idle after reset", 32'(dn_valid), 32'h0);
    check(!rsp_valid, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);

    // directed corners: wrap (R4), split in one 8-byte block (R3), single (R2)
    for (int w = 0; w < 2; w++) begin
      do_req(16'hFFFD, 4, w[0], 32'hA1B2C3D4);
      do_req(16'hFFFE, 4, w[0], 32'h11223344);
      do_req(16'hFFFF, 4, w[0], 32'h55667788);
      do_req(16'hFFFF, 2, w[0], 32'h0000BEEF);
      do_req(16'hFFFE, 2, w[0], 32'h0000CAFE);
      do_req(16'hFFFC, 4, w[0], 32'hDEADBEEF);
      do_req(16'h0003, 2, w[0], 32'h00001234);
      do_req(16'h0006, 4, w[0], 32'h89ABCDEF);
      do_req(16'h0005, 4, w[0], 32'h13579BDF);
      do_req(16'h0004, 4, w[0], 32'h2468ACE0);
      do_req(16'h0001, 1, w[0], 32'h0000005A);
      do_req(16'h1237, 1, w[0], 32'h000000C3);
    end

    // random mix, then a phase with heavy downstream stalls (R6)
    for (int p = 0; p < 2; p++) begin
      stall_heavy = p[0];
      for (int i = 0; i < 300; i++) begin
        n = ($urandom % 3 == 0) ? 1 : (($urandom % 2 == 0) ? 2 : 4);
        a = ($urandom % 3 == 0) ? 16'(16'hFFF8 + ($urandom % 8)) : 16'($urandom);
        do_req(a, n, ($urandom % 2) == 1, $urandom);
      end
    end

    while (exp_tx.size() > 0 || exp_rsp.size() > 0) @(posedge clk);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(!rsp_valid && !dn_valid, "R9", "quiet after drain", 32'(rsp_valid), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule